// File: doc/BRIEF.md
# Fast link-drop monitor

The monitor watches four link-quality indications from a 10/100 transceiver's receive path and asks the link state machine to drop the link as soon as an enabled one goes bad. Three of the indications are single-cycle pulses: receive-interface errors, line-code violations and low-SNR threshold crossings. The fourth is a level that reports loss of signal energy. A 4-bit enable mask picks the conditions that may act, and the request is the OR of those conditions, so any combination can be armed at once.

Each pulse source has its own event counter. All three counters share one free-running window of `WIN_LEN` clock cycles, which is 500 cycles at 50 MHz for a 10 µs interval. Every counter clears at the window boundary. A source trips in the cycle its count reaches its threshold, not at the end of the window. Energy loss has to stay asserted for `LOSS_HOLD` consecutive cycles before it trips, which filters short glitches. A trip gives a one-cycle `drop_o` pulse. A sticky cause vector records which conditions fired until software clears it.

Top module: `lnkmon_fastdrop`

## Requirements
- R1: After reset, `drop_o` is 0, `cause_o` is 4'b0000 and every event and loss counter is zero.
- R2: With mask bit 3 set, the `RXERR_THR`-th receive-error pulse inside one window (default 32) trips the condition and sets `cause_o[3]`. Fewer pulses do not trip it.
- R3: With mask bit 2 set, the `VIOL_THR`-th line-code-violation pulse inside one window (default 20) trips the condition and sets `cause_o[2]`. Fewer pulses do not trip it.
- R4: With mask bit 1 set, the `SNR_THR`-th low-SNR crossing pulse inside one window (default 20) trips the condition and sets `cause_o[1]`. Fewer pulses do not trip it.
- R5: With mask bit 0 set, energy loss that stays high for `LOSS_HOLD` consecutive cycles trips on the last of those cycles and sets `cause_o[0]`. A shorter run does not trip and restarts the count. A run that continues past the trip does not trip again until loss has gone low. This path does not depend on window boundaries.
- R6: The window is `WIN_LEN` cycles long and repeats without a gap, starting with the first cycle after reset. All event counters clear in the last cycle of each window, so events on both sides of a boundary never add up.
- R7: An event counter saturates at its threshold. A source trips at most once per window, and further events in that window cause no drop.
- R8: While its mask bit is 0, a condition never trips, never sets its cause bit and has its counter held at zero. After the bit is set mid-window, counting starts from zero.
- R9: `drop_o` is high for exactly one cycle per trip. It rises in the cycle after the clock edge that samples the tripping event, and it is the OR of all enabled trips.
- R10: `cause_o` bits stay set until `cause_clr_i` is sampled high, which zeroes them. A trip in the same cycle as a clear still sets its bit.
- R11: With the mask at 4'b0000, no input activity ever produces `drop_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_mask_i | input | 4 | Condition enables: [3] rx error, [2] code violation, [1] low SNR, [0] energy loss |
| rx_err_i | input | 1 | Receive-interface error pulse |
| code_viol_i | input | 1 | Line-code violation pulse |
| snr_low_i | input | 1 | Low-SNR threshold crossing pulse |
| energy_loss_i | input | 1 | Energy-loss level |
| cause_clr_i | input | 1 | Clears the sticky cause vector |
| drop_o | output | 1 | One-cycle link-drop request |
| cause_o | output | 4 | Sticky record of tripped conditions, same bit order as the mask |

## Verification
The bench sweeps every burst length from zero to one past each threshold and checks the count boundary in both directions. A threshold that is off by one either trips one event early or misses the trip. A run of one event short of the threshold is split across a window boundary: a counter that does not clear would trip there, and a counter that clears one cycle late or early shifts which events count. Two further cases cover masking. Events arrive while a bit is disabled and the bit is then enabled mid-window; a counter that keeps counting while disabled trips early. A clear and a trip are also made to land in the same cycle; a clear that wins would lose the cause bit. Finally, a long energy-loss run checks that the design gives a single drop pulse rather than a repeating one.

// File: rtl/lnkmon_pkg.sv
package lnkmon_pkg;
  // Positions in the enable mask and cause vector
  localparam int CB_ENERGY = 0;
  localparam int CB_SNR    = 1;
  localparam int CB_VIOL   = 2;
  localparam int CB_RXERR  = 3;
  localparam int N_COND    = 4;

  typedef logic [N_COND-1:0] cond_vec_t;
endpackage

// File: rtl/lnkmon_window.sv
module lnkmon_window #(
  parameter int WIN_LEN = 500
) (
  input  logic clk,
  input  logic rst,
  output logic win_last_o
);
  localparam int WW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [WW-1:0] LAST = WW'(WIN_LEN - 1);

  logic [WW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst)                 phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                     phase_q <= phase_q + 1'b1;
  end

  assign win_last_o = (phase_q == LAST);

  a_r6_phase_range: assert property (@(posedge clk) disable iff (rst)
    phase_q <= LAST);
  a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
    win_last_o |=> (phase_q == '0));
endmodule

// File: rtl/lnkmon_evcnt.sv
module lnkmon_evcnt #(
  parameter int THRESH = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic evt_i,
  input  logic win_last_i,
  output logic trip_o
);
  localparam int CW = $clog2(THRESH + 1);
  localparam logic [CW-1:0] CAP     = CW'(THRESH);
  localparam logic [CW-1:0] PRE_CAP = CW'(THRESH - 1);

  logic [CW-1:0] cnt_q;
  logic          at_cap;

  always_comb begin
    at_cap = (cnt_q == CAP);
    trip_o = en_i && evt_i && !at_cap && (cnt_q == PRE_CAP);
  end

  always_ff @(posedge clk) begin
    if (rst)                      cnt_q <= '0;
    else if (!en_i || win_last_i) cnt_q <= '0;
    else if (evt_i && !at_cap)    cnt_q <= cnt_q + 1'b1;
  end

  a_r7_saturate: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CAP);
  a_r8_held_zero: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (cnt_q == '0));
  a_r7_one_trip: assert property (@(posedge clk) disable iff (rst)
    (trip_o && !win_last_i) |=> (cnt_q == CAP));
  a_r6_clear_at_edge: assert property (@(posedge clk) disable iff (rst)
    win_last_i |=> (cnt_q == '0));
endmodule

// File: rtl/lnkmon_energy.sv
module lnkmon_energy #(
  parameter int HOLD = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic loss_i,
  output logic trip_o
);
  localparam int HW = $clog2(HOLD + 1);
  localparam logic [HW-1:0] FULL = HW'(HOLD);
  localparam logic [HW-1:0] PRE  = HW'(HOLD - 1);

  logic [HW-1:0] run_q;
  logic          active;

  always_comb begin
    active = en_i && loss_i;
    trip_o = active && (run_q == PRE);
  end

  always_ff @(posedge clk) begin
    if (rst)              run_q <= '0;
    else if (!active)     run_q <= '0;
    else if (run_q != FULL) run_q <= run_q + 1'b1;
  end

  a_r5_cap: assert property (@(posedge clk) disable iff (rst)
    run_q <= FULL);
  a_r5_restart: assert property (@(posedge clk) disable iff (rst)
    !loss_i |=> (run_q == '0));
  a_r5_no_retrip: assert property (@(posedge clk) disable iff (rst)
    trip_o |=> !trip_o);
endmodule

// File: rtl/lnkmon_fastdrop.sv
module lnkmon_fastdrop
  import lnkmon_pkg::*;
#(
  parameter int WIN_LEN   = 500,
  parameter int RXERR_THR = 32,
  parameter int VIOL_THR  = 20,
  parameter int SNR_THR   = 20,
  parameter int LOSS_HOLD = WIN_LEN
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] en_mask_i,
  input  logic       rx_err_i,
  input  logic       code_viol_i,
  input  logic       snr_low_i,
  input  logic       energy_loss_i,
  input  logic       cause_clr_i,
  output logic       drop_o,
  output logic [3:0] cause_o
);
  logic      win_last;
  cond_vec_t evt_vec;
  cond_vec_t trips;
  logic      drop_q;
  cond_vec_t cause_q;

  assign evt_vec[CB_RXERR]  = rx_err_i;
  assign evt_vec[CB_VIOL]   = code_viol_i;
  assign evt_vec[CB_SNR]    = snr_low_i;
  assign evt_vec[CB_ENERGY] = 1'b0;

  lnkmon_window #(.WIN_LEN(WIN_LEN)) win_i (
    .clk        (clk),
    .rst        (rst),
    .win_last_o (win_last)
  );

  for (genvar b = CB_SNR; b <= CB_RXERR; b++) begin : g_pulse
    localparam int THR = (b == CB_RXERR) ? RXERR_THR :
                         (b == CB_VIOL)  ? VIOL_THR  : SNR_THR;
    lnkmon_evcnt #(.THRESH(THR)) cnt_i (
      .clk        (clk),
      .rst        (rst),
      .en_i       (en_mask_i[b]),
      .evt_i      (evt_vec[b]),
      .win_last_i (win_last),
      .trip_o     (trips[b])
    );
  end

  lnkmon_energy #(.HOLD(LOSS_HOLD)) loss_i (
    .clk    (clk),
    .rst    (rst),
    .en_i   (en_mask_i[CB_ENERGY]),
    .loss_i (energy_loss_i),
    .trip_o (trips[CB_ENERGY])
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      drop_q  <= 1'b0;
      cause_q <= '0;
    end else begin
      drop_q  <= |trips;
      cause_q <= (cause_clr_i ? '0 : cause_q) | trips;
    end
  end

  assign drop_o  = drop_q;
  assign cause_o = cause_q;

  a_r10_cause_on_drop: assert property (@(posedge clk) disable iff (rst)
    drop_o |-> (cause_o != '0));
  a_r11_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    ($past(en_mask_i) == 4'b0000) |-> !drop_o);
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    !$past(cause_clr_i) |-> ((cause_o & $past(cause_o)) == $past(cause_o)));
  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    ($past(cause_clr_i) && !drop_o) |-> (cause_o == '0));
  a_r8_masked_bit: assert property (@(posedge clk) disable iff (rst)
    (!$past(en_mask_i[CB_VIOL]) && $past(cause_clr_i)) |-> !cause_o[CB_VIOL]);
endmodule

// File: tb/lnkmon_fastdrop_tb_top.sv
module lnkmon_fastdrop_tb_top;
  localparam int W   = 16;
  localparam int TRX = 6;
  localparam int TCV = 4;
  localparam int TSN = 5;
  localparam int EH  = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst;
  logic [3:0] en;
  logic       rx, cv, sn, el, clr;
  logic       drop;
  logic [3:0] cause;

  lnkmon_fastdrop #(
    .WIN_LEN(W), .RXERR_THR(TRX), .VIOL_THR(TCV), .SNR_THR(TSN), .LOSS_HOLD(EH)
  ) dut_i (
    .clk(clk), .rst(rst), .en_mask_i(en), .rx_err_i(rx), .code_viol_i(cv),
    .snr_low_i(sn), .energy_loss_i(el), .cause_clr_i(clr),
    .drop_o(drop), .cause_o(cause)
  );

  int    n_chk = 0, n_bad = 0, drops = 0;
  bit    done = 1'b0;
  string tag = "R1";
  int    ph, ecnt;
  int    c [1:3];
  logic  m_drop;
  logic [3:0] m_cause;

  function automatic int thr(int b);
    return (b == 3) ? TRX : (b == 2) ? TCV : TSN;
  endfunction

  task automatic chk(string t, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", t, what, got, exp);
    end
  endtask

  // Called at a negedge: drive, take one edge, update expectations, compare.
  task automatic cyc(input logic [3:1] ev, input logic loss, input logic cl);
    logic [3:0] t;
    rx = ev[3]; cv = ev[2]; sn = ev[1]; el = loss; clr = cl;
    @(posedge clk);
    t = '0;
    for (int b = 1; b <= 3; b++)
      if (en[b] && ev[b] && c[b] == thr(b) - 1) t[b] = 1'b1;
    if (en[0] && loss && ecnt == EH - 1) t[0] = 1'b1;
    for (int b = 1; b <= 3; b++) begin
      if (ph == W - 1 || !en[b]) c[b] = 0;
      else if (ev[b] && c[b] < thr(b)) c[b] = c[b] + 1;
    end
    if (en[0] && loss) begin
      if (ecnt < EH) ecnt = ecnt + 1;
    end else ecnt = 0;
    m_drop  = |t;
    m_cause = (cl ? 4'b0 : m_cause) | t;
    ph = (ph + 1) % W;
    @(negedge clk);
    if (drop) drops++;
    chk(tag, "drop_o R9", int'(drop), int'(m_drop));
    chk(tag, "cause_o R10", int'(cause), int'(m_cause));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(3'b000, 1'b0, 1'b0);
  endtask

  task automatic align();
    while (ph != 0) cyc(3'b000, 1'b0, 1'b0);
  endtask

  task automatic clear_cause();
    cyc(3'b000, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; en = '0; rx = 0; cv = 0; sn = 0; el = 0; clr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    ph = 0; ecnt = 0; c[1] = 0; c[2] = 0; c[3] = 0; m_cause = '0; m_drop = 0;
    // R1: reset state
    chk("R1", "drop_o", int'(drop), 0);
    chk("R1", "cause_o", int'(cause), 0);

    // R11: everything active, mask off
    tag = "R11";
    drops = 0;
    for (int i = 0; i < 3 * W; i++) cyc(3'b111, 1'b1, 1'b0);
    chk("R11", "drop count", drops, 0);
    idle(1);

    // R2 R3 R4 R7: burst length sweeps per source
    for (int b = 3; b >= 1; b--) begin
      en = 4'(1 << b);
      tag = (b == 3) ? "R2" : (b == 2) ? "R3" : "R4";
      for (int n = 0; n <= thr(b) + 1; n++) begin
        align();
        drops = 0;
        for (int i = 0; i < n; i++) cyc(3'(1 << (b - 1)), 1'b0, 1'b0);
        align();
        chk(tag, "R7 drops per window", drops, (n >= thr(b)) ? 1 : 0);
        chk(tag, "cause bit", int'(cause[b]), (n >= thr(b)) ? 1 : 0);
        clear_cause();
      end
    end

    // R6: threshold-1 events at window end plus one after the boundary
    tag = "R6";
    en = 4'b1000;
    align();
    idle(W - (TRX - 1));
    drops = 0;
    for (int i = 0; i < TRX - 1; i++) cyc(3'b100, 1'b0, 1'b0);
    chk("R6", "phase at boundary", ph, 0);
    cyc(3'b100, 1'b0, 1'b0);
    align();
    chk("R6", "split burst drops", drops, 0);

    // R8: disabled source ignored, then enabled mid-window from zero
    tag = "R8";
    en = 4'b1000;
    align();
    drops = 0;
    for (int i = 0; i < TCV + 2; i++) cyc(3'b010, 1'b0, 1'b0);
    chk("R8", "disabled drops", drops, 0);
    chk("R8", "disabled cause", int'(cause), 0);
    align();
    en = 4'b0000;
    for (int i = 0; i < TCV - 1; i++) cyc(3'b010, 1'b0, 1'b0);
    en = 4'b0100;
    for (int i = 0; i < TCV - 1; i++) cyc(3'b010, 1'b0, 1'b0);
    chk("R8", "restart from zero drops", drops, 0);
    cyc(3'b010, 1'b0, 1'b0);
    chk("R8", "trip after enable", int'(drop), 1);
    clear_cause();

    // R5: energy loss runs, off window alignment
    tag = "R5";
    en = 4'b0001;
    idle(3);
    drops = 0;
    for (int i = 0; i < EH - 1; i++) cyc(3'b000, 1'b1, 1'b0);
    idle(1);
    chk("R5", "short run drops", drops, 0);
    for (int i = 0; i < EH + 7; i++) cyc(3'b000, 1'b1, 1'b0);
    chk("R5", "long run drops", drops, 1);
    chk("R5", "cause bit0", int'(cause), 1);
    idle(1);
    clear_cause();

    // R9 R10: all pulse sources together, trips on consecutive cycles
    tag = "R9";
    en = 4'b1110;
    align();
    drops = 0;
    for (int i = 0; i < TRX + 2; i++) cyc(3'b111, 1'b0, 1'b0);
    chk("R9", "pulses from three sources", drops, 3);
    chk("R10", "accumulated cause", int'(cause), 4'b1110);
    // R10: clear colliding with a trip keeps the new bit only
    tag = "R10";
    en = 4'b0100;
    align();
    for (int i = 0; i < TCV - 1; i++) cyc(3'b010, 1'b0, 1'b0);
    cyc(3'b010, 1'b0, 1'b1);
    chk("R10", "clear with trip", int'(cause), 4'b0100);
    clear_cause();
    chk("R10", "clear alone", int'(cause), 0);
    idle(2);
    chk("R10", "stays clear", int'(cause), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule